// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block watches a bank of GPIO pad inputs and drives a small set of interrupt request lines. Each output channel has its own pad selector. The chosen pad is brought into the clock domain by a two-stage synchronizer and then shaped according to the channel's trigger setting:

- **Level:** the pad passes through as a level, either as it is or inverted.
- **Single edge:** the channel emits a one-cycle pulse on a rising edge or a falling edge of the pad.
- **Dual edge:** the channel emits a one-cycle pulse on every change of the pad.

A single global enable bit gates all channels at once.

Software sets the block up through a plain synchronous register port. A write takes effect on the clock edge where `reg_we_i` is high. The read data is a combinational function of `reg_addr_i`. Addresses are byte offsets, and only the word index `reg_addr_i[4:2]` is decoded. The register port and the interrupt lines carry single-cycle control information, so neither has a handshake or back-pressure. A downstream interrupt controller samples `irq_o` every cycle.

Top module: `gim_irq_mux`

## Requirements
- R1: After reset, all eight register words read as zero and every `irq_o` bit is low.
- R2: Word 0 (offset 0x00) holds three fields. Bits 11:0 are per-channel polarity (1 = active-low level or falling edge). Bits 23:12 are per-channel single-edge enables (1 = edge, 0 = level). Bit 31 is the global enable. Reads return the stored fields, and bits 30:24 read as zero.
- R3: Words 1 to 6 (offsets 0x04 to 0x18) each carry two 8-bit pad selectors. In word X, bits 7:0 select the pad for channel 2X-2 and bits 23:16 select the pad for channel 2X-1. All other bits read as zero. Several channels may select the same pad, and each one applies its own trigger.
- R4: In level mode with polarity 0, `irq_o[c]` equals the selected pad as it was sampled three rising clock edges earlier.
- R5: In level mode with polarity 1, `irq_o[c]` is the inverse of that delayed pad value.
- R6: In single-edge mode with polarity 0, `irq_o[c]` is high for exactly one cycle for each 0-to-1 change of the synchronized pad, with the same three-edge latency.
- R7: In single-edge mode with polarity 1, `irq_o[c]` is high for exactly one cycle for each 1-to-0 change of the synchronized pad.
- R8: Word 7 (offset 0x1c) bits 11:0 are per-channel dual-edge enables, and its other bits read as zero. A set bit makes that channel pulse for one cycle on any change of its synchronized pad, whatever its polarity and single-edge bits hold.
- R9: A selector value of 82 or more routes a constant zero into the channel.
- R10: While the global enable is 0, every `irq_o` bit is low from the cycle after the enable register clears. The other configuration fields keep their values.
- R11: A channel in single-edge mode with unchanged configuration never drives `irq_o` high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pad_i | input | 82 | Asynchronous GPIO pad levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 12 | Interrupt request lines, one per channel |

## Verification
Two triggers can act on the same pad change in the same cycle, so the bench tests them together. In a mixed sweep, four channels select one shared pad, one channel in each of the level, rising, falling and dual-edge modes. A fifth channel holds both the dual-edge bit and the single-edge bit. A single pad transition therefore produces a level change, a one-cycle pulse and a suppressed pulse all on the same edge. Each channel is compared against an arithmetic reference built from the delayed pad history. A second pairing is provoked by clearing the global enable while a toggling pad keeps producing edges. The bench then judges that no pulse leaks out after the enable has cleared.

// File: rtl/gim_pkg.sv
package gim_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 5;
  localparam int SEL_W      = 8;
  localparam int MAX_CH     = 12;
  // Field positions that software decodes
  localparam int POL_LSB    = 0;
  localparam int TRIG_LSB   = 12;
  localparam int EN_BIT     = 31;
  localparam int SEL_HI_LSB = 16;
  // Word indices (byte offset / 4)
  localparam logic [2:0] WORD_CTRL = 3'd0;
  localparam logic [2:0] WORD_DUAL = 3'd7;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE  = 2'd1,
    TRIG_DUAL  = 2'd2
  } trig_mode_e;
endpackage

// File: rtl/gim_sync.sv
module gim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= d_i;
      end
      assign q_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], d_i};
      end
      assign q_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gim_regs.sv
module gim_regs
  import gim_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic [NUM_CH-1:0]            pol_o,
  output logic [NUM_CH-1:0]            trig_o,
  output logic [NUM_CH-1:0]            dual_o,
  output logic                         en_o,
  output logic [NUM_CH-1:0][SEL_W-1:0] sel_o
);
  logic [2:0] widx;
  assign widx = addr_i[4:2];

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i[30:24]};

  logic [NUM_CH-1:0] pol_q, trig_q, dual_q;
  logic              en_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      trig_q <= '0;
      en_q   <= 1'b0;
    end else if (we_i && widx == WORD_CTRL) begin
      pol_q  <= wdata_i[POL_LSB  +: NUM_CH];
      trig_q <= wdata_i[TRIG_LSB +: NUM_CH];
      en_q   <= wdata_i[EN_BIT];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                        dual_q <= '0;
    else if (we_i && widx == WORD_DUAL) dual_q <= wdata_i[NUM_CH-1:0];
  end

  // Two selectors per word: even channel low byte, odd channel at bit 16
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
      localparam logic [2:0] WIDX = 3'(c / 2 + 1);
      localparam int         LSB  = (c % 2) * SEL_HI_LSB;
      logic [SEL_W-1:0] sel_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)                   sel_q <= '0;
        else if (we_i && widx == WIDX) sel_q <= wdata_i[LSB +: SEL_W];
      end
      assign sel_o[c] = sel_q;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (widx == WORD_CTRL) begin
      rdata_o[POL_LSB  +: NUM_CH] = pol_q;
      rdata_o[TRIG_LSB +: NUM_CH] = trig_q;
      rdata_o[EN_BIT]             = en_q;
    end else if (widx == WORD_DUAL) begin
      rdata_o[NUM_CH-1:0] = dual_q;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (widx == 3'(c / 2 + 1))
          rdata_o[(c % 2) * SEL_HI_LSB +: SEL_W] = sel_o[c];
      end
    end
  end

  assign pol_o  = pol_q;
  assign trig_o = trig_q;
  assign dual_o = dual_q;
  assign en_o   = en_q;
endmodule

// File: rtl/gim_chan.sv
module gim_chan
  import gim_pkg::*;
#(
  parameter int NUM_PADS    = 82,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                pol_i,
  input  logic                trig_i,
  input  logic                dual_i,
  input  logic                en_i,
  output logic                irq_o
);
  // Out-of-range selectors match no pad and yield zero
  logic picked;
  always_comb begin
    picked = 1'b0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (sel_i == SEL_W'(p)) picked = pad_i[p];
    end
  end

  logic cur;
  gim_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (picked),
    .q_o   (cur)
  );

  logic prv_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) prv_q <= 1'b0;
    else         prv_q <= cur;
  end

  trig_mode_e mode;
  always_comb begin
    if (dual_i)      mode = TRIG_DUAL;
    else if (trig_i) mode = TRIG_EDGE;
    else             mode = TRIG_LEVEL;
  end

  logic fire;
  always_comb begin
    unique case (mode)
      TRIG_DUAL: fire = cur ^ prv_q;
      TRIG_EDGE: fire = pol_i ? (prv_q & ~cur) : (cur & ~prv_q);
      default:   fire = cur ^ pol_i;
    endcase
  end

  logic irq_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i & fire;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/gim_irq_mux.sv
module gim_irq_mux
  import gim_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int NUM_PADS    = 82,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic                reg_we_i,
  input  logic [4:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_CH-1:0]            pol, trig, dual;
  logic                         glob_en;
  logic [NUM_CH-1:0][SEL_W-1:0] sel;

  gim_regs #(.NUM_CH(NUM_CH)) regs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .pol_o  (pol),
    .trig_o (trig),
    .dual_o (dual),
    .en_o   (glob_en),
    .sel_o  (sel)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      gim_chan #(.NUM_PADS(NUM_PADS), .SYNC_STAGES(SYNC_STAGES)) chan_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pad_i (pad_i),
        .sel_i (sel[c]),
        .pol_i (pol[c]),
        .trig_i(trig[c]),
        .dual_i(dual[c]),
        .en_i  (glob_en),
        .irq_o (irq_o[c])
      );
    end
  endgenerate
endmodule

// File: rtl/gim_irq_mux_chk.sv
module gim_irq_mux_chk #(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [4:0]        addr,
  input logic [31:0]       wdata,
  input logic [NUM_CH-1:0] irq,
  input logic              glob_en,
  input logic [NUM_CH-1:0] pol,
  input logic [NUM_CH-1:0] trig,
  input logic [NUM_CH-1:0] dual
);
  logic unused_chk;
  assign unused_chk = ^{addr[1:0], wdata[30:NUM_CH]};

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq == '0); // R1

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[4:2] == 3'd0) |=> glob_en == $past(wdata[31])); // R2

  AST_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[4:2] == 3'd7) |=> dual == $past(wdata[NUM_CH-1:0])); // R8

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> irq == '0); // R10

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pw
      AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[c] && $past(trig[c]) && !$past(dual[c]) && trig[c] && !dual[c]
         && pol[c] == $past(pol[c])) |=> !irq[c]); // R11
    end
  endgenerate
endmodule

bind gim_irq_mux gim_irq_mux_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .we     (reg_we_i),
  .addr   (reg_addr_i),
  .wdata  (reg_wdata_i),
  .irq    (irq_o),
  .glob_en(glob_en),
  .pol    (pol),
  .trig   (trig),
  .dual   (dual)
);

// File: tb/gim_irq_mux_tb_top.sv
module gim_irq_mux_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 12;
  localparam int NUM_PADS   = 82;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NUM_PADS-1:0] pads = '0;
  logic                we = 1'b0;
  logic [4:0]          addr = '0;
  logic [31:0]         wdata = '0;
  logic [31:0]         rdata;
  logic [NUM_CH-1:0]   irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gim_irq_mux #(.NUM_CH(NUM_CH), .NUM_PADS(NUM_PADS)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pad_i      (pads),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  // Reference: pad history sampled on each rising edge
  logic [NUM_PADS-1:0] hist [4];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] <= '0;
    end else begin
      hist[0] <= pads;
      hist[1] <= hist[0];
      hist[2] <= hist[1];
      hist[3] <= hist[2];
    end
  end

  logic [NUM_CH-1:0] m_pol = '0, m_trig = '0, m_dual = '0;
  logic              m_en = 1'b0;
  logic [7:0]        m_sel [NUM_CH];
  logic [31:0]       lfsr = 32'h1ACE_B00C;

  function automatic logic [NUM_CH-1:0] exp_irq();
    logic [NUM_CH-1:0] r;
    for (int c = 0; c < NUM_CH; c++) begin
      logic cur, prv;
      cur = (m_sel[c] < NUM_PADS) ? hist[2][m_sel[c]] : 1'b0;
      prv = (m_sel[c] < NUM_PADS) ? hist[3][m_sel[c]] : 1'b0;
      if (!m_en)          r[c] = 1'b0;
      else if (m_dual[c]) r[c] = cur ^ prv;
      else if (m_trig[c]) r[c] = m_pol[c] ? (prv & ~cur) : (cur & ~prv);
      else                r[c] = cur ^ m_pol[c];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic push_cfg();
    logic [31:0] d;
    d = '0;
    d[11:0]  = m_pol;
    d[23:12] = m_trig;
    d[31]    = m_en;
    wr(5'h00, d);
    for (int x = 1; x <= 6; x++)
      wr(5'(4 * x), {8'h00, m_sel[2*x-1], 8'h00, m_sel[2*x-2]});
    wr(5'h1c, {20'h0, m_dual});
  endtask

  task automatic run(input string tag, input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i >= 5) chk(tag, 32'(irq), 32'(exp_irq()));
      if (i % hold == 0) begin
        lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
        pads = {lfsr[17:0], lfsr ^ 32'h5A5A_A5A5, lfsr};
      end
    end
  endtask

  task automatic finish_sim();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) m_sel[c] = 8'(c * 7);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", 32'(irq), 32'h0);
    for (int w = 0; w < 8; w++) rd_chk(5'(4 * w), 32'h0, "R1 reg");

    // R2, R3, R8: readback with unused bits zero
    wr(5'h00, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'h80FF_FFFF, "R2 ctrl");
    wr(5'h0C, 32'hFFFF_FFFF);
    rd_chk(5'h0C, 32'h00FF_00FF, "R3 sel word");
    wr(5'h0C, 32'h1234_5678);
    rd_chk(5'h0C, 32'h0034_0078, "R3 sel fields");
    wr(5'h1c, 32'hFFFF_FFFF);
    rd_chk(5'h1c, 32'h0000_0FFF, "R8 dual");
    wr(5'h00, 32'h0);
    wr(5'h1c, 32'h0);

    // Uniform-mode sweeps; selectors spread over pads and out of range
    for (int c = 0; c < NUM_CH; c++) m_sel[c] = 8'((c * 13 + 3) % 90);
    m_sel[11] = 8'd255;
    m_en = 1'b1;
    for (int h = 1; h <= 3; h += 2) begin
      m_pol = '0;   m_trig = '0;   m_dual = '0; push_cfg(); run("R4 level high", 50, h);
      m_pol = '1;   m_trig = '0;   m_dual = '0; push_cfg(); run("R5 level low",  50, h);
      m_pol = '0;   m_trig = '1;   m_dual = '0; push_cfg(); run("R6 rise R11",   50, h);
      m_pol = '1;   m_trig = '1;   m_dual = '0; push_cfg(); run("R7 fall R11",   50, h);
      m_pol = 12'hA5C; m_trig = 12'h3C9; m_dual = '1; push_cfg(); run("R8 dual override", 50, h);
    end

    // R9: every selector out of range routes zero
    for (int c = 0; c < NUM_CH; c++) m_sel[c] = 8'(82 + c * 14);
    m_pol = '0; m_trig = '0; m_dual = '0; push_cfg();
    run("R9 out of range", 30, 1);
    m_pol = '1; push_cfg();
    run("R9 inverted zero", 20, 1);

    // R3: shared pad, different modes on the same change
    for (int c = 0; c < NUM_CH; c++) m_sel[c] = 8'd5;
    m_sel[10] = 8'd81; m_sel[11] = 8'd0;
    m_pol = 12'b0000_0100_0110; m_trig = 12'b0001_0001_1100; m_dual = 12'b0000_0001_0001;
    push_cfg();
    run("R3 mixed shared pad", 60, 1);
    run("R3 mixed slow", 60, 4);

    // R10: global enable cleared during activity
    m_trig = '0; m_pol = '0; m_dual = 12'h0F0;
    push_cfg();
    m_en = 1'b0;
    wr(5'h00, {8'h00, 12'h000, 12'h000});
    run("R10 disabled", 40, 1);
    m_pol = 12'h00F; m_trig = 12'hF00;
    wr(5'h00, {8'h00, 12'hF00, 12'h00F});
    rd_chk(5'h00, 32'h00F0_000F, "R10 cfg kept");
    rd_chk(5'h1c, 32'h0000_00F0, "R10 dual kept");
    run("R10 disabled edge cfg", 20, 1);

    done = 1'b1;
    finish_sim();
  end
endmodule